// File: doc/BRIEF.md
# Byte-Lane Bus Parity Generator and Checker

This block sits beside the 64-bit data path of a bus master. It produces and verifies one parity bit for each byte lane on every data beat of a tenure, whether the tenure has one beat or many. On a write beat it supplies eight parity bits that match the outgoing data and raises an output enable for them. On a read beat it computes parity from the received data, compares it with the parity bits that came with it, and records which lanes disagree.

Two control bits are sampled on each beat. One selects odd or even parity and governs both generation and checking. The other turns read checking on or off. A mismatch only updates a registered lane mask and a sticky error flag. The data always passes through unchanged in the same cycle and is never held back. A clear input resets the sticky flag.

Top module: `lane_parity_unit`

## Requirements
- R1: Lanes are numbered big-endian. `data_in[0]` is the most significant bit. Parity bit k (`par_out[k]`, `par_out[0]` most significant) covers `data_in[8k]` to `data_in[8k+7]`, so bit 0 covers the top byte.
- R2: With `odd_sel`=0, each parity bit is the XOR of its lane's 8 data bits. With `odd_sel`=1, it is the inverse of that XOR. The same selection applies to the compare on read beats.
- R3: `par_oe` is 1 exactly when `beat_vld`=1 and `beat_is_rd`=0. During such a beat `par_out` holds correct parity whatever the value of `chk_en`.
- R4: A checked read beat is one with `beat_vld`=1, `beat_is_rd`=1 and `chk_en`=1. On the clock edge that ends it, `err_mask` is loaded: bit k is 1 exactly when `par_in[k]` differs from the parity computed for lane k.
- R5: Any beat that is not a checked read beat leaves `err_mask` unchanged. This covers read beats with `chk_en`=0, write beats and idle cycles.
- R6: On the edge that ends a checked read beat with at least one lane mismatch, `err_flag` becomes 1.
- R7: `err_flag` stays 1 until a cycle with `err_clr`=1. It is 0 after that cycle's edge, even if a mismatching checked beat occurs in the same cycle.
- R8: In a burst of back-to-back read beats each beat is checked, and `err_mask` shows the result of each beat on the cycle after that beat.
- R9: `data_out` equals `data_in` in the same cycle, whatever the parity result.
- R10: After reset `err_mask` is 0 and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_vld | input | 1 | A data beat is on the bus this cycle |
| beat_is_rd | input | 1 | 1 = read beat, 0 = write beat |
| chk_en | input | 1 | Enables parity checking of read beats |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| err_clr | input | 1 | Clears the sticky error flag |
| data_in | input | 64 | Beat data, bit 0 most significant |
| par_in | input | 8 | Received parity, bit 0 for the top byte |
| data_out | output | 64 | Data forwarded unchanged |
| par_out | output | 8 | Generated parity for `data_in` |
| par_oe | output | 1 | Drive enable for `par_out` (write beats) |
| err_mask | output | 8 | Lanes that mismatched on the last checked read beat |
| err_flag | output | 1 | Sticky parity error flag |

## Verification
`par_out`, `par_oe` and `data_out` are combinational. The bench checks them one time unit after it drives the inputs, in the same cycle. `err_mask` and `err_flag` change on the edge that ends the beat. The bench drives each beat on a falling edge and checks these two outputs on the next falling edge, half a period after the register update. In a burst, the result of one beat is checked at the same falling edge where the next beat is driven. Beats that must be ignored are followed by a read of the unchanged mask and flag at that same point.

// File: rtl/lane_par_pkg.sv
package lane_par_pkg;
  localparam int unsigned BUS_BITS  = 64;
  localparam int unsigned LANE_BITS = 8;
  localparam int unsigned LANE_CNT  = BUS_BITS / LANE_BITS;

  typedef enum logic [1:0] {
    BEAT_IDLE  = 2'd0,
    BEAT_WRITE = 2'd1,
    BEAT_READ  = 2'd2
  } beat_kind_e;

  function automatic beat_kind_e classify(input logic vld, input logic is_rd);
    if (!vld) return BEAT_IDLE;
    return is_rd ? BEAT_READ : BEAT_WRITE;
  endfunction
endpackage

// File: rtl/lpu_lane_gen.sv
module lpu_lane_gen #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic [0:DATA_W-1] data,
  input  logic              odd_sel,
  output logic [0:LANES-1]  par
);
  function automatic logic lane_fold(input logic [LANE_W-1:0] v, input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < int'(LANE_W); i++) acc = acc ^ v[i];
    return acc;
  endfunction

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    assign par[k] = lane_fold(data[k*LANE_W +: LANE_W], odd_sel);
  end
endmodule

// File: rtl/lpu_err_track.sv
module lpu_err_track #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_hit,
  input  logic             clr,
  input  logic [0:LANES-1] calc,
  input  logic [0:LANES-1] rcvd,
  output logic [0:LANES-1] err_mask,
  output logic             err_flag
);
  logic [0:LANES-1] mismatch;
  logic             any_err;

  assign mismatch = calc ^ rcvd;
  assign any_err  = chk_hit && (|mismatch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_mask <= '0;
    else if (chk_hit) err_mask <= mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else if (clr) err_flag <= 1'b0;
    else if (any_err) err_flag <= 1'b1;
  end

  // R5: unchecked cycles hold the mask
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_hit |=> $stable(err_mask));
  // R4: a checked beat without mismatch leaves an all-clear mask
  a_r4_clean_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_hit && calc == rcvd) |=> (err_mask == '0));
  // R6: a mismatching checked beat raises the flag unless cleared
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !clr) |=> err_flag);
  // R7: clear wins, and the flag is otherwise sticky
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lane_par_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_BITS,
  parameter int unsigned LANE_W = LANE_BITS,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic              beat_is_rd,
  input  logic              chk_en,
  input  logic              odd_sel,
  input  logic              err_clr,
  input  logic [0:DATA_W-1] data_in,
  input  logic [0:LANES-1]  par_in,
  output logic [0:DATA_W-1] data_out,
  output logic [0:LANES-1]  par_out,
  output logic              par_oe,
  output logic [0:LANES-1]  err_mask,
  output logic              err_flag
);
  beat_kind_e       kind;
  logic             chk_hit;
  logic [0:LANES-1] lane_par;

  assign kind     = classify(beat_vld, beat_is_rd);
  assign chk_hit  = (kind == BEAT_READ) && chk_en;
  assign par_oe   = (kind == BEAT_WRITE);
  assign par_out  = lane_par;
  assign data_out = data_in;

  lpu_lane_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_gen (
    .data    (data_in),
    .odd_sel (odd_sel),
    .par     (lane_par)
  );

  lpu_err_track #(.LANES(LANES)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_hit  (chk_hit),
    .clr      (err_clr),
    .calc     (lane_par),
    .rcvd     (par_in),
    .err_mask (err_mask),
    .err_flag (err_flag)
  );

  // R3: enable only on write beats
  a_r3_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe == (beat_vld && !beat_is_rd));
  // R2: data plus parity of every lane has the selected polarity on writes
  for (genvar k = 0; k < int'(LANES); k++) begin : g_wchk
    a_r2_write_lane: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe |-> (($countones({data_in[k*LANE_W +: LANE_W], par_out[k]}) % 2) == 32'(odd_sel)));
  end
  // R9: forwarding is unaffected
  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    data_out == data_in);
endmodule

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_vld = 1'b0, beat_is_rd = 1'b0, chk_en = 1'b0, odd_sel = 1'b0, err_clr = 1'b0;
  logic [0:63] data_in = '0;
  logic [0:7]  par_in = '0;
  logic [0:63] data_out;
  logic [0:7]  par_out, err_mask;
  logic        par_oe, err_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_is_rd(beat_is_rd),
    .chk_en(chk_en), .odd_sel(odd_sel), .err_clr(err_clr),
    .data_in(data_in), .par_in(par_in), .data_out(data_out),
    .par_out(par_out), .par_oe(par_oe), .err_mask(err_mask), .err_flag(err_flag)
  );

  // Reference: count ones in each lane and take the low bit, then apply polarity.
  function automatic logic [0:7] ref_par(input logic [0:63] d, input logic odd);
    logic [0:7] r;
    for (int k = 0; k < 8; k++) begin
      int ones = 0;
      for (int j = 0; j < 8; j++) if (d[8*k + j]) ones++;
      r[k] = ((ones % 2) == 1) ? ~odd : odd;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    beat_vld = 0; beat_is_rd = 0; err_clr = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle();
    repeat (2) @(negedge clk);
    check("R10 mask", 64'(err_mask), 64'h0);
    check("R10 flag", 64'(err_flag), 64'h0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_write_gen();
    @(negedge clk);
    beat_vld = 1; beat_is_rd = 0; chk_en = 0; odd_sel = 0;
    data_in = 64'h01000000_00000000;
    #1;
    check("R1 top lane", 64'(par_out), 64'h80);
    check("R3 oe write", 64'(par_oe), 64'h1);
    data_in = 64'h00000000_00000003;
    #1;
    check("R1 bottom lane even", 64'(par_out), 64'h00);
    data_in = 64'h00000000_00000007;
    #1;
    check("R1 bottom lane", 64'(par_out), 64'h01);
    odd_sel = 1;
    data_in = 64'hA5F0_1234_FFFF_0E81;
    #1;
    check("R2 odd", 64'(par_out), 64'(ref_par(data_in, 1'b1)));
    odd_sel = 0;
    #1;
    check("R2 even", 64'(par_out), 64'(ref_par(data_in, 1'b0)));
    beat_is_rd = 1;
    #1;
    check("R3 oe read", 64'(par_oe), 64'h0);
    beat_vld = 0;
    #1;
    check("R3 oe idle", 64'(par_oe), 64'h0);
    idle();
  endtask

  task automatic t_read_check();
    @(negedge clk);
    beat_vld = 1; beat_is_rd = 1; chk_en = 1; odd_sel = 1;
    data_in = 64'h0123_4567_89AB_CDEF;
    par_in = ref_par(data_in, 1'b1) ^ 8'b0010_0001;
    #1;
    check("R9 pass", data_out, data_in);
    @(negedge clk);
    idle();
    check("R4 mask", 64'(err_mask), 64'h21);
    check("R6 flag", 64'(err_flag), 64'h1);
    @(negedge clk);
    check("R7 sticky", 64'(err_flag), 64'h1);
    check("R5 idle hold", 64'(err_mask), 64'h21);
  endtask

  task automatic t_ignored();
    @(negedge clk);
    beat_vld = 1; beat_is_rd = 1; chk_en = 0;
    data_in = 64'hFFFF_0000_1111_2222;
    par_in = 8'hFF;
    @(negedge clk);
    check("R5 chk off", 64'(err_mask), 64'h21);
    beat_is_rd = 0; chk_en = 1;
    @(negedge clk);
    idle();
    check("R5 write", 64'(err_mask), 64'h21);
  endtask

  task automatic t_clear();
    @(negedge clk);
    err_clr = 1;
    beat_vld = 1; beat_is_rd = 1; chk_en = 1; odd_sel = 0;
    data_in = 64'h8000_0000_0000_0000;
    par_in = 8'h00;
    @(negedge clk);
    idle();
    check("R7 clear priority", 64'(err_flag), 64'h0);
    check("R4 mask on clear cycle", 64'(err_mask), 64'h80);
    @(negedge clk);
    check("R7 stays clear", 64'(err_flag), 64'h0);
  endtask

  task automatic t_burst();
    logic [0:63] d [4];
    logic [0:7]  inj [4];
    d[0] = 64'h1122_3344_5566_7788; inj[0] = 8'h00;
    d[1] = 64'hDEAD_BEEF_0BAD_F00D; inj[1] = 8'h40;
    d[2] = 64'h0000_0000_0000_0001; inj[2] = 8'h03;
    d[3] = 64'hFEDC_BA98_7654_3210; inj[3] = 8'h00;
    @(negedge clk);
    beat_vld = 1; beat_is_rd = 1; chk_en = 1; odd_sel = 1;
    for (int b = 0; b < 4; b++) begin
      data_in = d[b];
      par_in = ref_par(d[b], 1'b1) ^ inj[b];
      @(negedge clk);
      check($sformatf("R8 beat %0d", b), 64'(err_mask), 64'(inj[b]));
    end
    idle();
    check("R6 burst flag", 64'(err_flag), 64'h1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_gen();
        t_read_check();
        t_ignored();
        t_clear();
        t_burst();
        repeat (2) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule